// File: doc/BRIEF.md
# Half-width serial word link with optional XOR-difference coding

This block carries 64-bit words between two points of a chip over a 32-lane link. Each word is cut into two half-width beats. The link runs on a clock at twice the word rate, so one word still crosses per word period, as it would on a full 64-lane bus. The transmit and receive ends share one module. The link lanes and a first-beat marker are brought out so the traffic on the lanes can be observed.

One word period spans two link clock cycles. The block marks the link edges that open a word period with `word_slot`. A word offered while `word_slot` is high is taken at the next edge. A mode input picks between two codings. In plain coding the raw word goes on the lanes. In difference coding the lanes carry the bitwise XOR of the word with the previous word taken. With this coding a stream of repeated addresses leaves every lane still. The receiver undoes the coding with its own copy of the last word it rebuilt. When no word is offered, the lanes keep their last value.

Top module: `serdes_link`

## Requirements
- R1: The block takes a word only at an edge where `word_slot` is high and `in_valid` is high. `word_slot` is high in the first cycle after reset and alternates every link cycle after that. `in_valid`, `in_data` and `diff_en` are ignored at every other edge.
- R2: After a word is taken, `link_data` carries bits 31:0 of the coded word for one cycle with `link_first` = 1. In the next cycle it carries bits 63:32 with `link_first` = 0.
- R3: With `diff_en` = 0 at the taking edge, the coded word equals the input word.
- R4: With `diff_en` = 1 at the taking edge, the coded word equals the input word XOR the previous word taken. Both ends track this previous word in both codings. It is all zeros after reset, so a first word sent in difference coding goes out unchanged.
- R5: In difference coding, a word equal to the previous word taken is sent as two all-zero beats.
- R6: For a word taken at edge t, `out_valid` goes high at edge t+2 and stays high for exactly two cycles, with `out_data` equal to the original word. `out_data` holds its value until the next word arrives.
- R7: When no word is taken, `link_data` holds its last driven value and `link_first` stays 0.
- R8: Under synchronous active-low reset, `link_data`, `out_data`, `link_first` and `out_valid` are all 0.
- R9: The coding can change from one word to the next in either direction, and every word is still rebuilt correctly. A change of `diff_en` within a word period has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, twice the word rate |
| rst_n | input | 1 | Synchronous reset, active low |
| diff_en | input | 1 | 1 selects difference coding, sampled with each word taken |
| in_valid | input | 1 | Word offered |
| in_data | input | 64 | Word to send |
| word_slot | output | 1 | High when the next edge opens a word period |
| link_data | output | 32 | Link lanes |
| link_first | output | 1 | High while the lanes carry the low half of a word |
| out_valid | output | 1 | Rebuilt word present, high for two link cycles |
| out_data | output | 64 | Rebuilt word |

## Verification
The assertions assume that inputs change only between edges. They also assume that both ends start from the same reset, so the phase of the link beats is fixed by `word_slot` alone. The bench drives inputs on falling edges only. Within each word period it offers either a word or an idle slot. In the second half of every word period it drives random junk on `in_valid`, `in_data` and `diff_en`, which checks that these inputs are ignored there. The coding is chosen at random for each word, and repeated words are injected on purpose, so that all-zero beats and changes of coding from one word to the next both occur.

// File: rtl/serdes_link.sv
module serdes_link #(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              diff_en,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              word_slot,
  output logic [WORD_W/2-1:0] link_data,
  output logic              link_first,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);
  localparam int LANE_W = WORD_W / 2;

  logic              phase;
  logic [WORD_W-1:0] tx_prev, rx_prev;
  logic [LANE_W-1:0] tx_hi, rx_lo;
  logic              tx_mode, tx_pend, rx_mode, rx_have;

  assign word_slot = ~phase;

  wire              take    = ~phase & in_valid;
  wire [WORD_W-1:0] coded   = in_data ^ (diff_en ? tx_prev : '0);
  wire [WORD_W-1:0] rebuilt = {link_data, rx_lo} ^ (rx_mode ? rx_prev : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= 1'b0;
      link_data  <= '0;
      link_first <= 1'b0;
      tx_hi      <= '0;
      tx_prev    <= '0;
      tx_mode    <= 1'b0;
      tx_pend    <= 1'b0;
    end else begin
      phase <= ~phase;
      if (take) begin
        link_data  <= coded[LANE_W-1:0];
        tx_hi      <= coded[WORD_W-1:LANE_W];
        tx_prev    <= in_data;
        tx_mode    <= diff_en;
        link_first <= 1'b1;
        tx_pend    <= 1'b1;
      end else begin
        link_first <= 1'b0;
        tx_pend    <= 1'b0;
        if (tx_pend) link_data <= tx_hi;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_lo     <= '0;
      rx_mode   <= 1'b0;
      rx_have   <= 1'b0;
      rx_prev   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      rx_have <= link_first;
      if (link_first) begin
        rx_lo   <= link_data;
        rx_mode <= tx_mode;
      end
      if (!phase) begin
        out_valid <= rx_have;
        if (rx_have) begin
          out_data <= rebuilt;
          rx_prev  <= rebuilt;
        end
      end
    end
  end
endmodule

module serdes_link_chk #(
  parameter int WORD_W = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                word_slot,
  input logic [WORD_W/2-1:0] link_data,
  input logic                link_first,
  input logic                out_valid
);
  // R1
  slot_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_slot |=> !word_slot);
  // R1
  slot_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_slot |=> word_slot);
  // R2
  first_beat_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_first |=> !link_first);
  // R2
  first_beat_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_first |-> !word_slot);
  // R6
  out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(link_first, 2));
  // R6
  out_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |=> out_valid);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_first && !$past(link_first)) |-> $stable(link_data));
endmodule

bind serdes_link serdes_link_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_slot(word_slot),
  .link_data(link_data), .link_first(link_first), .out_valid(out_valid)
);

// File: tb/tb_serdes_link.sv
module tb_serdes_link;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        diff_en = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        word_slot, link_first, out_valid;
  logic [31:0] link_data;
  logic [63:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [63:0] prev_word = '0;
  logic [31:0] last_link = '0;
  logic [63:0] last_out = '0;
  logic        prev_v = 1'b0;

  always #2 clk = ~clk;

  serdes_link dut (
    .clk(clk), .rst_n(rst_n), .diff_en(diff_en), .in_valid(in_valid),
    .in_data(in_data), .word_slot(word_slot), .link_data(link_data),
    .link_first(link_first), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic do_slot(input bit v, input logic [63:0] d, input bit m);
    logic [63:0] enc;
    string req;
    enc = m ? (d ^ prev_word) : d;
    req = !m ? "R3" : (d == prev_word ? "R5" : "R4");
    chk("R1 slot open", {63'd0, word_slot}, 64'd1);
    in_valid = v; in_data = d; diff_en = m;
    @(posedge clk); @(negedge clk);
    chk("R1 slot closed", {63'd0, word_slot}, 64'd0);
    chk(v ? "R2 first flag" : "R7 idle flag", {63'd0, link_first}, {63'd0, v});
    if (v) begin
      chk(req, {32'd0, link_data}, {32'd0, enc[31:0]});
      last_link = enc[63:32];
    end else chk("R7 hold", {32'd0, link_data}, {32'd0, last_link});
    chk("R6 valid", {63'd0, out_valid}, {63'd0, prev_v});
    chk("R6 data", out_data, last_out);
    in_valid = 1'($urandom); in_data = {$urandom, $urandom}; diff_en = 1'($urandom);
    @(posedge clk); @(negedge clk);
    chk("R2 second flag", {63'd0, link_first}, 64'd0);
    chk(v ? req : "R7 hold", {32'd0, link_data}, {32'd0, last_link});
    chk("R6 valid held", {63'd0, out_valid}, {63'd0, prev_v});
    chk("R1 R9 data held", out_data, last_out);
    prev_v = v;
    if (v) begin
      prev_word = d;
      last_out = d;
    end
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2025));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8
    chk("R8 link", {32'd0, link_data}, 64'd0);
    chk("R8 first", {63'd0, link_first}, 64'd0);
    chk("R8 valid", {63'd0, out_valid}, 64'd0);
    chk("R8 out", out_data, 64'd0);
    do_slot(1'b1, 64'hDEAD_BEEF_0123_4567, 1'b1);
    do_slot(1'b1, 64'hDEAD_BEEF_0123_4567, 1'b1);
    do_slot(1'b0, 64'h0, 1'b0);
    do_slot(1'b1, 64'h1111_2222_3333_4444, 1'b0);
    do_slot(1'b1, 64'h1111_2222_3333_4444, 1'b1);
    do_slot(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    do_slot(1'b1, 64'h0, 1'b1);
    for (int i = 0; i < 400; i++) begin
      logic [63:0] d;
      d = ($urandom % 4 == 0) ? prev_word : {$urandom, $urandom};
      do_slot(($urandom % 5) != 0, d, 1'($urandom));
    end
    do_slot(1'b0, 64'h0, 1'b0);
    do_slot(1'b0, 64'h0, 1'b0);
    finish_run();
  end
endmodule